// File: doc/BRIEF.md
# Aligned-Pair Dual-Issue Controller

This block sits at the issue stage of a two-way in-order core that fetches instructions as 8-byte aligned groups of two. Each cycle it receives the decoded descriptors of both slots of the group (valid bit, operation class, two source register indices, a destination index and a write flag). It decides whether each slot issues in this cycle. The older slot (slot 0) may issue together with the younger slot (slot 1) only when the two do not depend on each other and do not compete for a shared execution resource. The shared resources are two integer ALUs, one data-cache port and one multiply/divide unit.

A small per-register scoreboard tracks load results that are still in flight. An instruction that reads such a register, or writes it, waits until the result is usable. Issue order is always preserved: when slot 0 is held, slot 1 is held too. An invalid slot, such as the first half of a group entered through an odd target, issues nothing and takes no resource.

Top module: `dual_issue_ctrl`

## Requirements
- R1: Class codes are 0 = ALU, 1 = branch/jump/call, 2 = load, 3 = store, 4 = multiply/divide, 5 = multi-part. Codes 6 and 7 are unknown and behave exactly like 5. An instruction of class 5, 6 or 7 never issues in the same cycle as a valid partner.
- R2: A slot issues only if its valid bit is 1. An invalid slot 0 places no resource or dependency constraint on slot 1.
- R3: Any two of classes 0 and 1 (one ALU each, two ALUs available) issue together when they are independent and their sources are ready.
- R4: Two instructions from classes 2 and 3 (the single cache port) never issue in the same cycle. Slot 1 is held instead.
- R5: Two class-4 instructions never issue in the same cycle. Slot 1 is held instead.
- R6: If slot 0 is valid, has its write flag set and names a non-zero destination, slot 1 is held when either of its sources equals that destination, or when slot 1 also writes that same destination.
- R7: When a load with a non-zero destination issues in cycle t, an instruction that reads that register cannot issue in cycles t+1 and t+2, and may issue in cycle t+3. This applies to either slot.
- R8: An instruction whose write flag is set and whose destination is still pending from a load is held as in R7.
- R9: Register index 0 never creates a dependency. A load to register 0 leaves nothing pending, and sources or destinations equal to 0 never match.
- R10: If slot 0 is valid and not issued, slot 1 is not issued either.
- R11: hold0 equals slot 0 valid and not issued. stall1 equals slot 1 valid and not issued.
- R12: After reset no register is pending, so an independent instruction issues in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_class | input | 3 | Slot 0 operation class (R1) |
| s0_src_a | input | REG_W | Slot 0 first source register |
| s0_src_b | input | REG_W | Slot 0 second source register |
| s0_dst | input | REG_W | Slot 0 destination register |
| s0_wr | input | 1 | Slot 0 writes its destination |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_class | input | 3 | Slot 1 operation class (R1) |
| s1_src_a | input | REG_W | Slot 1 first source register |
| s1_src_b | input | REG_W | Slot 1 second source register |
| s1_dst | input | REG_W | Slot 1 destination register |
| s1_wr | input | 1 | Slot 1 writes its destination |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| hold0 | output | 1 | Slot 0 valid but held |
| stall1 | output | 1 | Slot 1 valid but held |

## Verification
The assertions take it for granted that the slot inputs stay stable through a cycle and are not X while out of reset. They also assume that unused source fields are set to register 0 rather than left floating. The load-shadow property further assumes that a load's destination and write flag describe the instruction that really issued. The stimulus changes inputs only just after a rising edge and drives every field to a defined value. During reset and between sweep cases it keeps both valid bits low. Idle cycles after each case let every pending count drain, so each sweep case starts from an empty scoreboard.

// File: rtl/dip_pkg.sv
package dip_pkg;

  // Operation class encoding; 6 and 7 decode like CL_MULTI.
  typedef enum logic [2:0] {
    CL_ALU   = 3'd0,
    CL_BR    = 3'd1,
    CL_LD    = 3'd2,
    CL_ST    = 3'd3,
    CL_MD    = 3'd4,
    CL_MULTI = 3'd5
  } op_class_e;

  // Resources claimed by one slot in its issue cycle.
  typedef struct packed {
    logic alu;   // one integer ALU
    logic mem;   // the data-cache port
    logic md;    // the multiply/divide unit
    logic excl;  // everything: issues alone
  } res_use_t;

  function automatic res_use_t class_use(input logic [2:0] c);
    res_use_t u;
    u = '0;
    case (c)
      CL_ALU, CL_BR: u.alu  = 1'b1;
      CL_LD, CL_ST:  u.mem  = 1'b1;
      CL_MD:         u.md   = 1'b1;
      default:       u.excl = 1'b1;
    endcase
    return u;
  endfunction

  function automatic logic is_load(input logic [2:0] c);
    return c == CL_LD;
  endfunction

  // True when the two claims fit the shared resources in one cycle.
  function automatic logic pair_fits(input res_use_t a, input res_use_t b,
                                     input int unsigned n_alu);
    int unsigned alus;
    alus = 32'(a.alu) + 32'(b.alu);
    return !(a.excl || b.excl) && !(a.mem && b.mem) && !(a.md && b.md) &&
           (alus <= n_alu);
  endfunction

endpackage

// File: rtl/dip_slot_decode.sv
module dip_slot_decode
  import dip_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             valid,
  input  logic [2:0]       cls,
  input  logic [REG_W-1:0] dst,
  input  logic             wr,
  output res_use_t         use_o,
  output logic             load_wr
);
  // An invalid slot claims nothing.
  always_comb begin
    use_o   = valid ? class_use(cls) : '0;
    load_wr = valid && is_load(cls) && wr && (dst != '0);
  end
endmodule

// File: rtl/dip_scoreboard.sv
module dip_scoreboard #(
  parameter int REG_W    = 5,
  parameter int LOAD_LAT = 3,
  parameter int NQ       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_idx,
  input  logic [REG_W-1:0] q_idx [NQ],
  output logic [NQ-1:0]    q_busy
);
  localparam int NREG  = 1 << REG_W;
  localparam int CNT_W = (LOAD_LAT > 2) ? $clog2(LOAD_LAT) : 1;
  localparam logic [CNT_W-1:0] START = CNT_W'(LOAD_LAT - 1);

  // Cycles left until each register's load result is usable.
  logic [CNT_W-1:0] cnt [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (set_en && (set_idx == REG_W'(i))) cnt[i] <= START;
        else if (cnt[i] != '0)                cnt[i] <= cnt[i] - 1'b1;
      end
    end
  end

  // Index 0 is never set, so it always reads as free.
  always_comb begin
    for (int q = 0; q < NQ; q++) q_busy[q] = (cnt[q_idx[q]] != '0);
  end
endmodule

// File: rtl/dip_pair_arbiter.sv
module dip_pair_arbiter
  import dip_pkg::*;
#(
  parameter int N_ALU = 2
) (
  input  logic [1:0] valid,
  input  logic [1:0] ready,
  input  res_use_t   use0,
  input  res_use_t   use1,
  input  logic       dep,
  output logic [1:0] issue,
  output logic       conflict
);
  always_comb begin
    conflict = !pair_fits(use0, use1, N_ALU);
    issue[0] = valid[0] && ready[0];
    // Slot 1 goes alone behind an empty slot 0, or beside an issuing one.
    issue[1] = valid[1] && ready[1] &&
               (!valid[0] || (issue[0] && !dep && !conflict));
  end
endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
  import dip_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int LOAD_LAT = 3,
  parameter int N_ALU    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_valid,
  input  logic [2:0]       s0_class,
  input  logic [REG_W-1:0] s0_src_a,
  input  logic [REG_W-1:0] s0_src_b,
  input  logic [REG_W-1:0] s0_dst,
  input  logic             s0_wr,
  input  logic             s1_valid,
  input  logic [2:0]       s1_class,
  input  logic [REG_W-1:0] s1_src_a,
  input  logic [REG_W-1:0] s1_src_b,
  input  logic [REG_W-1:0] s1_dst,
  input  logic             s1_wr,
  output logic             issue0,
  output logic             issue1,
  output logic             hold0,
  output logic             stall1
);
  localparam int NSLOT = 2;
  localparam int QPS   = 3;            // queries per slot: src_a, src_b, dst
  localparam int NQ    = NSLOT * QPS;

  // Slot 1 needs slot 0's result, or both write the same register.
  function automatic logic pair_dep(input logic wr0, input logic [REG_W-1:0] d0,
                                    input logic [REG_W-1:0] a1,
                                    input logic [REG_W-1:0] b1,
                                    input logic wr1, input logic [REG_W-1:0] d1);
    return wr0 && (d0 != '0) && ((a1 == d0) || (b1 == d0) || (wr1 && d1 == d0));
  endfunction

  logic             v   [NSLOT];
  logic [2:0]       cls [NSLOT];
  logic [REG_W-1:0] dst [NSLOT];
  logic             wr  [NSLOT];
  res_use_t         use_s [NSLOT];
  logic             ldw [NSLOT];

  assign v[0] = s0_valid;  assign v[1] = s1_valid;
  assign cls[0] = s0_class; assign cls[1] = s1_class;
  assign dst[0] = s0_dst;  assign dst[1] = s1_dst;
  assign wr[0] = s0_wr;    assign wr[1] = s1_wr;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      dip_slot_decode #(.REG_W(REG_W)) u_dec (
        .valid  (v[g]),
        .cls    (cls[g]),
        .dst    (dst[g]),
        .wr     (wr[g]),
        .use_o  (use_s[g]),
        .load_wr(ldw[g])
      );
    end
  endgenerate

  // Scoreboard queries
  logic [REG_W-1:0] q_idx [NQ];
  logic [NQ-1:0]    q_busy;
  assign q_idx[0] = s0_src_a; assign q_idx[1] = s0_src_b; assign q_idx[2] = s0_dst;
  assign q_idx[3] = s1_src_a; assign q_idx[4] = s1_src_b; assign q_idx[5] = s1_dst;

  // Named internal events, observed by the checker
  logic [1:0] slot_ready;
  logic       pair_dep_w;
  logic       pair_conflict;
  logic [1:0] issue_w;
  logic       sb_set;
  logic [REG_W-1:0] sb_idx;

  generate
    for (g = 0; g < NSLOT; g++) begin : g_ready
      assign slot_ready[g] = !(q_busy[g*QPS] || q_busy[g*QPS+1] ||
                               (wr[g] && q_busy[g*QPS+2]));
    end
  endgenerate

  assign pair_dep_w = s0_valid &&
                      pair_dep(s0_wr, s0_dst, s1_src_a, s1_src_b, s1_wr, s1_dst);

  dip_pair_arbiter #(.N_ALU(N_ALU)) u_arb (
    .valid   ({s1_valid, s0_valid}),
    .ready   (slot_ready),
    .use0    (use_s[0]),
    .use1    (use_s[1]),
    .dep     (pair_dep_w),
    .issue   (issue_w),
    .conflict(pair_conflict)
  );

  // At most one load issues per cycle (single cache port).
  assign sb_set = (issue_w[0] && ldw[0]) || (issue_w[1] && ldw[1]);
  assign sb_idx = (issue_w[0] && ldw[0]) ? s0_dst : s1_dst;

  dip_scoreboard #(.REG_W(REG_W), .LOAD_LAT(LOAD_LAT), .NQ(NQ)) u_sb (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (sb_set),
    .set_idx(sb_idx),
    .q_idx  (q_idx),
    .q_busy (q_busy)
  );

  assign issue0 = issue_w[0];
  assign issue1 = issue_w[1];
  assign hold0  = s0_valid && !issue_w[0];
  assign stall1 = s1_valid && !issue_w[1];
endmodule

// File: rtl/dip_checker.sv
module dip_checker #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s0_valid,
  input logic [2:0]       s0_class,
  input logic [REG_W-1:0] s0_src_a,
  input logic [REG_W-1:0] s0_dst,
  input logic             s0_wr,
  input logic             s1_valid,
  input logic [2:0]       s1_class,
  input logic [REG_W-1:0] s1_src_a,
  input logic [REG_W-1:0] s1_src_b,
  input logic             issue0,
  input logic             issue1,
  input logic             sb_set,
  input logic [REG_W-1:0] sb_idx
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  logic mem0, mem1, both;
  assign mem0 = (s0_class == 3'd2) || (s0_class == 3'd3);
  assign mem1 = (s1_class == 3'd2) || (s1_class == 3'd3);
  assign both = issue0 && issue1;

  a_r2_valid0: assert property (@(posedge clk) disable iff (!rst_n)
    issue0 |-> s0_valid);
  a_r2_valid1: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> s1_valid);
  a_r10_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> (!s0_valid || issue0));
  a_r1_alone: assert property (@(posedge clk) disable iff (!rst_n)
    both |-> (s0_class < 3'd5) && (s1_class < 3'd5));
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    both |-> !(mem0 && mem1));
  a_r5_one_muldiv: assert property (@(posedge clk) disable iff (!rst_n)
    both |-> !(s0_class == 3'd4 && s1_class == 3'd4));
  a_r6_no_pair_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (both && s0_wr && s0_dst != '0) |-> (s1_src_a != s0_dst) && (s1_src_b != s0_dst));
  // R7: the cycle after a load is recorded, a reader of it does not issue.
  a_r7_load_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(sb_set) && s0_valid && s0_src_a == $past(sb_idx)) |-> !issue0);
  a_r9_no_zero_entry: assert property (@(posedge clk) disable iff (!rst_n)
    sb_set |-> sb_idx != '0);
endmodule

bind dual_issue_ctrl dip_checker #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s0_valid(s0_valid), .s0_class(s0_class), .s0_src_a(s0_src_a),
  .s0_dst(s0_dst), .s0_wr(s0_wr),
  .s1_valid(s1_valid), .s1_class(s1_class), .s1_src_a(s1_src_a),
  .s1_src_b(s1_src_b),
  .issue0(issue0), .issue1(issue1), .sb_set(sb_set), .sb_idx(sb_idx)
);

// File: tb/test_dual_issue_ctrl.sv
module test_dual_issue_ctrl;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s0_valid = 0, s0_wr = 0, s1_valid = 0, s1_wr = 0;
  logic [2:0] s0_class = 0, s1_class = 0;
  logic [RW-1:0] s0_src_a = 0, s0_src_b = 0, s0_dst = 0;
  logic [RW-1:0] s1_src_a = 0, s1_src_b = 0, s1_dst = 0;
  logic issue0, issue1, hold0, stall1;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  dual_issue_ctrl #(.REG_W(RW), .LOAD_LAT(3), .N_ALU(2)) i_dual_issue_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_class(s0_class), .s0_src_a(s0_src_a),
    .s0_src_b(s0_src_b), .s0_dst(s0_dst), .s0_wr(s0_wr),
    .s1_valid(s1_valid), .s1_class(s1_class), .s1_src_a(s1_src_a),
    .s1_src_b(s1_src_b), .s1_dst(s1_dst), .s1_wr(s1_wr),
    .issue0(issue0), .issue1(issue1), .hold0(hold0), .stall1(stall1)
  );

  task automatic set0(input logic v, input logic [2:0] c, input int a, input int b,
                      input int d, input logic w);
    s0_valid = v; s0_class = c; s0_src_a = RW'(a); s0_src_b = RW'(b);
    s0_dst = RW'(d); s0_wr = w;
  endtask

  task automatic set1(input logic v, input logic [2:0] c, input int a, input int b,
                      input int d, input logic w);
    s1_valid = v; s1_class = c; s1_src_a = RW'(a); s1_src_b = RW'(b);
    s1_dst = RW'(d); s1_wr = w;
  endtask

  task automatic go();
    @(posedge clk); #1;
  endtask

  // Sample in the low phase; all four outputs follow from the two issues (R11).
  task automatic look(input string req, input logic e0, input logic e1);
    logic eh, es;
    @(negedge clk);
    eh = s0_valid && !e0;
    es = s1_valid && !e1;
    checks++;
    if ({issue0, issue1, hold0, stall1} !== {e0, e1, eh, es}) begin
      fails++;
      $display("FAIL %s: i0 i1 h0 s1 = %b%b%b%b expected %b%b%b%b (c0=%0d c1=%0d v=%b%b)",
               req, issue0, issue1, hold0, stall1, e0, e1, eh, es,
               s0_class, s1_class, s0_valid, s1_valid);
    end
  endtask

  task automatic idle(input int n);
    set0(0, 0, 0, 0, 0, 0); set1(0, 0, 0, 0, 0, 0);
    repeat (n) go();
  endtask

  // Bench's own resource arithmetic: ALU count, port and unit sharing.
  function automatic int alu_n(input int c); return (c <= 1) ? 1 : 0; endfunction
  function automatic bit mem_of(input int c); return c == 2 || c == 3; endfunction
  function automatic bit writes(input int c); return !(c == 1 || c == 3); endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: expired, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12: reset state, and nothing pending right after reset
    look("R12", 0, 0);
    go(); set0(1, 0, 5, 6, 9, 1); set1(1, 0, 7, 8, 10, 1);
    look("R12", 1, 1);
    idle(1);

    // Sweep: R1 R2 R3 R4 R5 R6 over classes, valids and dependency shapes
    for (int c0 = 0; c0 < 8; c0++)
      for (int c1 = 0; c1 < 8; c1++)
        for (int vm = 0; vm < 4; vm++)
          for (int dp = 0; dp < 3; dp++) begin
            bit v0, v1, w0, w1, dep, conf, e1;
            v0 = vm[0]; v1 = vm[1];
            w0 = writes(c0); w1 = writes(c1);
            dep = v0 && w0 && ((dp == 1) || (dp == 2 && w1));
            conf = v0 && v1 && ((c0 >= 5) || (c1 >= 5) ||
                   (mem_of(c0) && mem_of(c1)) || (c0 == 4 && c1 == 4) ||
                   (alu_n(c0) + alu_n(c1) > 2));
            e1 = v1 && (!v0 || (!dep && !conf));
            go();
            set0(v0, 3'(c0), 1, 2, 7, w0);
            set1(v1, 3'(c1), (dp == 1) ? 7 : 3, 4, (dp == 2) ? 7 : 8, w1);
            look("R1 R2 R3 R4 R5 R6", v0, e1);
            idle(3);
          end

    // R7: slot 0 reader of a loaded register, cycles t+1..t+3
    go(); set0(1, 2, 1, 2, 5, 1); look("R7", 1, 0);
    go(); set0(1, 0, 5, 2, 9, 1); look("R7", 0, 0);
    go(); look("R7", 0, 0);
    go(); look("R7", 1, 0);
    idle(3);

    // R7: slot 1 reader behind an empty slot 0
    go(); set0(1, 2, 1, 2, 6, 1); look("R7", 1, 0);
    go(); set0(0, 0, 0, 0, 0, 0); set1(1, 0, 3, 6, 11, 1); look("R7", 0, 0);
    go(); look("R7", 0, 0);
    go(); look("R7", 0, 1);
    idle(3);

    // R10: pending slot 0 holds an independent slot 1
    go(); set0(1, 2, 1, 2, 5, 1); look("R10", 1, 0);
    go(); set0(1, 0, 5, 2, 9, 1); set1(1, 0, 3, 4, 10, 1); look("R10", 0, 0);
    idle(3);

    // R8: writing a register whose load is pending
    go(); set0(1, 2, 1, 2, 5, 1); look("R8", 1, 0);
    go(); set0(1, 0, 1, 2, 5, 1); look("R8", 0, 0);
    go(); set0(1, 0, 1, 2, 5, 0); look("R8", 1, 0);
    idle(3);

    // R9: load to register 0 leaves nothing pending; 0 never matches in a pair
    go(); set0(1, 2, 1, 2, 0, 1); look("R9", 1, 0);
    go(); set0(1, 0, 0, 0, 9, 1); look("R9", 1, 0);
    go(); set0(1, 0, 1, 2, 0, 1); set1(1, 0, 0, 0, 0, 1); look("R9", 1, 1);
    idle(3);

    summary();
  end
endmodule